// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor's load/store port and a slower word-wide memory. It keeps a small direct-mapped store of one-word lines. Each line carries a valid flag, a dirty flag, a tag and one data word. Stores that hit stay in the cache and mark the line dirty. Main memory is brought up to date only when a dirty line is evicted. The memory write of the old contents always happens before the replacement word is read.

A configuration input selects how a store miss is handled, and it is sampled when the request is accepted:
- **Write-allocate:** the store installs its word as a dirty line.
- **Write-no-allocate:** the word goes straight to memory and the cache is left untouched.

The processor side uses a ready/request handshake with a one-cycle completion pulse and a hit flag. The memory side raises a request and waits for an acknowledge.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `cpu_done` is 0 and `mem_req` is 0. Every line is invalid, so the first access to any address is reported as a miss.
- R2: The low `IDX_W` address bits select the line and the remaining upper bits form the tag. Two addresses that share the low bits but differ above them evict each other, while addresses with different low bits can be resident together.
- R3: A load that hits returns the line's word with `cpu_hit`=1 and makes no memory access. This includes a word stored earlier that has not yet been written to memory.
- R4: A store that hits replaces the line's word, marks the line dirty and makes no memory access.
- R5: A miss that must replace a valid dirty line first writes the old word to the address formed from the old tag and the index. Only after that write is acknowledged does the next memory access begin.
- R6: A load miss reads the requested address exactly once, returns that word and installs it as a valid clean line. Replacing a clean or invalid line causes no memory write.
- R7: With `wr_alloc`=0, a store miss performs exactly one memory write of the store data to the store address. It changes no line, so whatever was resident at that index still hits with its old word.
- R8: With `wr_alloc`=1, a store miss installs the store data as a valid dirty line without reading memory, so a later load of that address hits.
- R9: With `wr_alloc`=0 and two addresses on different lines, starting from an empty cache, the sequence load A, store B, store A, load A, load B, load B, load A reports miss, miss, hit, hit, miss, hit, hit.
- R10: `cpu_ready` is 0 from the cycle after a request is accepted until the cycle in which `cpu_done` pulses high for exactly one cycle. `cpu_hit` and `cpu_rdata` are valid while `cpu_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_alloc | input | 1 | 1 = allocate on store miss, 0 = write around; sampled at acceptance |
| cpu_req | input | 1 | Request, accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access hit the cache (valid with `cpu_done`) |
| cpu_rdata | output | DATA_W | Load result (valid with `cpu_done`) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
Latency depends on the path taken:
- **Hit:** completes two edges after acceptance.
- **Miss:** adds one memory round trip per access, and a dirty-victim load miss adds two.

Rather than predict a fixed cycle, the bench steps on falling edges until `cpu_done` is seen. While it waits it checks that `cpu_ready` stays low, and it reads the hit flag and data on that completion cycle. The memory model logs every access it acknowledges, so the order, kind and address of the writeback and fill are compared against the reference.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_alloc,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FILL, S_WAR} st_t;
  st_t st;

  logic [LINES-1:0]  vld, drt;
  logic [TAG_W-1:0]  tags [LINES];
  logic [DATA_W-1:0] dat  [LINES];

  logic              req_we, req_alloc;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tg;
  logic hit, vic_dirty, line_wr;

  assign idx       = req_addr[IDX_W-1:0];
  assign tg        = req_addr[ADDR_W-1:IDX_W];
  assign hit       = vld[idx] && (tags[idx] == tg);
  assign vic_dirty = vld[idx] && drt[idx];
  assign line_wr   = (st == S_LOOK && req_we && (hit || (req_alloc && !vic_dirty)))
                   || (st == S_WB && mem_ack && req_we)
                   || (st == S_FILL && mem_ack);

  assign cpu_ready = (st == S_IDLE);
  assign mem_req   = (st == S_WB) || (st == S_FILL) || (st == S_WAR);
  assign mem_we    = (st == S_WB) || (st == S_WAR);
  assign mem_addr  = (st == S_WB) ? {tags[idx], idx} : req_addr;
  assign mem_wdata = (st == S_WB) ? dat[idx] : req_wdata;

  always_ff @(posedge clk) begin
    if (line_wr) begin
      tags[idx] <= tg;
      dat[idx]  <= (st == S_FILL) ? mem_rdata : req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld       <= '0;
      drt       <= '0;
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
      req_we    <= 1'b0;
      req_alloc <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (line_wr) begin
        vld[idx] <= 1'b1;
        drt[idx] <= req_we;
      end
      case (st)
        S_IDLE: if (cpu_req) begin
          req_we    <= cpu_we;
          req_alloc <= wr_alloc;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          st        <= S_LOOK;
        end
        S_LOOK: begin
          cpu_hit <= hit;
          if (hit) begin
            if (!req_we) cpu_rdata <= dat[idx];
            cpu_done <= 1'b1;
            st       <= S_IDLE;
          end else if (req_we && !req_alloc) begin
            st <= S_WAR;
          end else if (vic_dirty) begin
            st <= S_WB;
          end else if (req_we) begin
            cpu_done <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          if (req_we) begin
            cpu_done <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          cpu_rdata <= mem_rdata;
          cpu_done  <= 1'b1;
          st        <= S_IDLE;
        end
        S_WAR: if (mem_ack) begin
          cpu_done <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_store_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && hit && req_we) |=> (!mem_req && drt[$past(idx)]));

  assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !req_we) |=> (mem_req && !mem_we && mem_addr == req_addr));

  assert_wb_old_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st == S_WB) |-> (mem_addr[IDX_W-1:0] == idx && mem_addr != req_addr));

  assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_ack) |=> (vld[$past(idx)] && !drt[$past(idx)] && cpu_done));

  assert_around_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAR && mem_ack) |=> (vld == $past(vld) && drt == $past(drt)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_ready);
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  localparam int AW = 8, DW = 16, IW = 3, LAT = 3;

  logic clk = 0, rst_n = 0, wr_alloc = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done, cpu_hit;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;

  always #5 clk = ~clk;

  dm_wb_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dm_wb_cache (
    .clk, .rst_n, .wr_alloc, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_ready, .cpu_done, .cpu_hit, .cpu_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata);

  logic [DW-1:0] mem [256];
  logic [DW-1:0] ref_mem [256];
  int cnt = 0;
  int op_n = 0;
  bit op_w [4];
  logic [AW-1:0] op_a [4];

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 0; cnt <= 0;
    end else if (mem_req) begin
      if (cnt == LAT) begin
        mem_ack <= 1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else mem_rdata <= mem[mem_addr];
        if (op_n < 4) begin op_w[op_n] <= mem_we; op_a[op_n] <= mem_addr; end
        op_n <= op_n + 1;
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  bit r_vld [8], r_drt [8];
  logic [AW-IW-1:0] r_tag [8];
  logic [DW-1:0] r_dat [8];
  logic [DW-1:0] truth [256];

  task automatic access(input string rq, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output bit got_hit);
    int i = int'(a[IW-1:0]);
    bit eh = r_vld[i] && r_tag[i] == a[AW-1:IW];
    int en = 0;
    bit ew [2];
    logic [AW-1:0] ea [2];
    logic [DW-1:0] erd = truth[a];
    bit busy_bad = 0;
    if (!eh) begin
      if (we && !wr_alloc) begin
        ew[0] = 1; ea[0] = a; en = 1; ref_mem[a] = d;
      end else begin
        if (r_vld[i] && r_drt[i]) begin
          ew[en] = 1; ea[en] = {r_tag[i], a[IW-1:0]}; en++;
          ref_mem[{r_tag[i], a[IW-1:0]}] = r_dat[i];
        end
        if (!we) begin ew[en] = 0; ea[en] = a; en++; end
        r_vld[i] = 1; r_tag[i] = a[AW-1:IW]; r_drt[i] = we; r_dat[i] = we ? d : truth[a];
      end
    end else if (we) begin
      r_dat[i] = d; r_drt[i] = 1;
    end
    if (we) truth[a] = d;
    @(negedge clk);
    op_n = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_done) begin
      if (cpu_ready) busy_bad = 1;
      @(negedge clk);
    end
    got_hit = cpu_hit;
    check(!busy_bad, {rq, " R10 stall"}, busy_bad, 0);
    check(cpu_hit == eh, {rq, " hit flag"}, cpu_hit, eh);
    if (!we) check(cpu_rdata == erd, {rq, " R3 load data"}, cpu_rdata, erd);
    check(op_n == en, {rq, " memory access count"}, op_n, en);
    for (int k = 0; k < en && k < op_n; k++)
      check(op_w[k] == ew[k] && op_a[k] == ea[k], {rq, " memory access order/address"},
            {op_w[k], op_a[k]}, {ew[k], ea[k]});
  endtask

  initial begin
    int seed;
    bit h;
    bit tr [7] = '{0, 0, 1, 1, 0, 1, 1};
    bit got [7];
    seed = $urandom(1234);
    for (int k = 0; k < 256; k++) begin
      mem[k] = DW'(k * 37 + 11); ref_mem[k] = mem[k]; truth[k] = mem[k];
    end
    for (int k = 0; k < 8; k++) begin r_vld[k] = 0; r_drt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cpu_ready && !cpu_done && !mem_req, "R1 reset state",
          {cpu_ready, cpu_done, mem_req}, 3'b100);

    wr_alloc = 0;
    access("R9", 0, 8'h12, 0, got[0]);
    access("R9", 1, 8'h35, 16'hB0B0, got[1]);
    access("R9", 1, 8'h12, 16'hA1A1, got[2]);
    access("R9", 0, 8'h12, 0, got[3]);
    access("R9", 0, 8'h35, 0, got[4]);
    access("R9", 0, 8'h35, 0, got[5]);
    access("R9", 0, 8'h12, 0, got[6]);
    for (int k = 0; k < 7; k++) check(got[k] == tr[k], "R9 trace", got[k], tr[k]);

    access("R4", 1, 8'h12, 16'h1234, h);
    access("R3", 0, 8'h12, 0, h);
    access("R2 R5", 0, 8'h52, 0, h);
    check(mem[8'h12] == 16'h1234, "R5 writeback data", mem[8'h12], 16'h1234);
    access("R6", 0, 8'h92, 0, h);
    access("R7", 1, 8'h13, 16'h7777, h);
    access("R7", 1, 8'h1D, 16'h5151, h);
    access("R7", 0, 8'h1D, 0, h);
    access("R7", 0, 8'h13, 0, h);
    wr_alloc = 1;
    access("R8", 1, 8'h44, 16'h8888, h);
    access("R8", 0, 8'h44, 0, h);
    check(h == 1, "R8 load after allocate hits", h, 1);
    access("R8 R5", 1, 8'h64, 16'h9999, h);
    access("R2", 0, 8'h45, 0, h);
    access("R2", 0, 8'h64, 0, h);
    check(h == 1, "R2 different lines coexist", h, 1);

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {3'b0, 2'($urandom % 4), 3'($urandom % 8)};
      if ($urandom % 16 == 0) wr_alloc = ~wr_alloc;
      access("RND", 1'($urandom % 2), a, 16'($urandom), h);
    end

    begin
      int bad = -1;
      for (int k = 0; k < 256; k++) if (bad < 0 && mem[k] !== ref_mem[k]) bad = k;
      check(bad < 0, "R5 R7 final memory image", bad, -1);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule